// File: doc/BRIEF.md
# XOR-Remapped Set Lookup with Block Turnoff

This block is the lookup front end of a set-associative data cache built to tolerate blocks that came out slow after manufacture. Each way holds its own index remap code. A lookup for logical set `s` reads physical row `s XOR code_k` in way `k`. The blocks of one logical set can therefore sit in different physical rows, which spreads slow blocks evenly over the logical sets.

A defect bitmap marks every slow physical block. For the addressed logical set, the block gathers the defect bits of the rows it reads and decides three things. It picks which ways stay powered: slow blocks are switched off unless every block of the set is slow. It picks whether the access takes the short or the long latency. It picks which enabled way holds a matching tag. The set of enabled ways is also the legal victim mask for a refill. A simple fill port writes tags so that hits can form. Data storage, replacement choice and latency prediction sit outside.

Top module: `xr_set_lookup`

## Requirements
- R1: An address is split into block offset (bits 5:0), set index (bits 12:6) and tag (bits 31:13) under the default 32 KB, 4-way, 64-byte geometry (128 sets). The offset bits have no effect on the result.
- R2: Way k reads physical row (set index XOR code_k). Every code resets to zero.
- R3: When none of the blocks read for a set is marked, all ways are enabled and the reported latency is 2 cycles with `rsp_slow` = 0.
- R4: When some but not all of the blocks read are marked, exactly the marked ways are disabled and the latency is 2 cycles.
- R5: When every block read is marked, all ways stay enabled, `rsp_slow` = 1 and the latency is 4 cycles. At least one way is always enabled.
- R6: The defect bit of way w, physical row r, is `defect_map[w*128 + r]`. A bit of a row that is not read for the set has no effect.
- R7: A disabled way never reports a hit, and `rsp_way_en` (the refill victim mask) has its bit cleared.
- R8: A hit is reported when an enabled way holds a valid line with an equal tag in its physical row. `rsp_way` is the lowest such way. On a miss, `rsp_hit` = 0 and `rsp_way` = 0.
- R9: Every response field is registered: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and never otherwise.
- R10: A fill writes the tag into `fill_way` at row (index XOR code of that way) and marks it valid. Lookups in later cycles see it; a lookup in the same cycle sees the state before the fill.
- R11: A code write is taken only in a cycle with `req_valid` and `fill_valid` both low. A taken write invalidates every line. A write in any other cycle changes nothing.
- R12: After reset no line is valid and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Lookup byte address |
| fill_valid | input | 1 | Tag fill strobe |
| fill_addr | input | 32 | Address whose tag is filled |
| fill_way | input | 2 | Way receiving the fill |
| remap_we | input | 1 | Remap code write strobe |
| remap_way | input | 2 | Way whose code is written |
| remap_code | input | 7 | New XOR code |
| defect_map | input | 512 | One bit per physical block, set when slow |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | An enabled way matched |
| rsp_way | output | 2 | Matching way, zero on miss |
| rsp_way_en | output | 4 | Enabled ways, also the refill victim mask |
| rsp_slow | output | 1 | Set accessed at the long latency |
| rsp_lat | output | 3 | Access latency in cycles (2 or 4) |

## Verification
A fill and a lookup can hit the same logical set in the same cycle. The bench provokes this by raising both strobes together with matching tag and index. The response must report a miss, because the lookup sees the tag state from before the edge. A plain lookup in the next cycle must then hit the filled way. A code write can also arrive together with a lookup. The bench judges that case by checking that a line filled earlier still hits at its old row afterwards.

// File: rtl/xr_lookup_pkg.sv
package xr_lookup_pkg;

  localparam int unsigned FAST_CYCLES = 2;
  localparam int unsigned SLOW_CYCLES = 4;

  typedef enum logic {
    LAT_FAST = 1'b0,
    LAT_SLOW = 1'b1
  } lat_class_e;

  // Latency in cycles for a latency class.
  function automatic logic [2:0] lat_cycles(lat_class_e c);
    return (c == LAT_SLOW) ? 3'(SLOW_CYCLES) : 3'(FAST_CYCLES);
  endfunction

endpackage

// File: rtl/xr_remap_bank.sv
module xr_remap_bank #(
  parameter int NUM_WAYS = 4,
  parameter int IDX_W    = 7,
  parameter int WAY_W    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [WAY_W-1:0]          wr_way,
  input  logic [IDX_W-1:0]          wr_code,
  input  logic [IDX_W-1:0]          lk_idx,
  input  logic [IDX_W-1:0]          fl_idx,
  input  logic [WAY_W-1:0]          fl_way,
  output logic [NUM_WAYS*IDX_W-1:0] lk_rows,
  output logic [IDX_W-1:0]          fl_row,
  output logic [NUM_WAYS*IDX_W-1:0] codes
);

  // Logical set index to physical row of one way.
  function automatic logic [IDX_W-1:0] xlate(logic [IDX_W-1:0] idx, logic [IDX_W-1:0] code);
    return idx ^ code;
  endfunction

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [IDX_W-1:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_q <= '0;
      end else if (wr_en && (wr_way == WAY_W'(w))) begin
        code_q <= wr_code;
      end
    end

    assign codes[w*IDX_W +: IDX_W]   = code_q;
    assign lk_rows[w*IDX_W +: IDX_W] = xlate(lk_idx, code_q);
  end

  always_comb begin
    fl_row = fl_idx;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (fl_way == WAY_W'(w)) begin
        fl_row = xlate(fl_idx, codes[w*IDX_W +: IDX_W]);
      end
    end
  end

endmodule

// File: rtl/xr_tag_bank.sv
module xr_tag_bank #(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 128,
  parameter int IDX_W    = 7,
  parameter int WAY_W    = 2,
  parameter int TAG_W    = 19
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_all,
  input  logic                      wr_en,
  input  logic [WAY_W-1:0]          wr_way,
  input  logic [IDX_W-1:0]          wr_row,
  input  logic [TAG_W-1:0]          wr_tag,
  input  logic [NUM_WAYS*IDX_W-1:0] rd_rows,
  output logic [NUM_WAYS-1:0]       rd_valid,
  output logic [NUM_WAYS*TAG_W-1:0] rd_tags
);

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [TAG_W-1:0]    tag_q [NUM_SETS];
    logic [NUM_SETS-1:0] vld_q;
    logic [IDX_W-1:0]    rd_row;
    logic                wr_hit_way;

    assign rd_row     = rd_rows[w*IDX_W +: IDX_W];
    assign wr_hit_way = wr_en && (wr_way == WAY_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
      end else if (clr_all) begin
        vld_q <= '0;
      end else if (wr_hit_way) begin
        vld_q[wr_row] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_hit_way) begin
        tag_q[wr_row] <= wr_tag;
      end
    end

    assign rd_valid[w]               = vld_q[rd_row];
    assign rd_tags[w*TAG_W +: TAG_W] = tag_q[rd_row];
  end

endmodule

// File: rtl/xr_turnoff.sv
module xr_turnoff #(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 128,
  parameter int IDX_W    = 7,
  parameter int WAY_W    = 2
) (
  input  logic [NUM_WAYS*NUM_SETS-1:0] defect_map,
  input  logic [NUM_WAYS*IDX_W-1:0]    rows,
  output logic [NUM_WAYS-1:0]          way_en,
  output logic                         slow
);

  localparam int SEL_W = WAY_W + IDX_W;

  logic [NUM_WAYS-1:0] bad;

  // Affected blocks go dark unless that would leave the set empty.
  function automatic logic [NUM_WAYS:0] resolve(logic [NUM_WAYS-1:0] b);
    logic all_bad;
    all_bad = &b;
    return all_bad ? {1'b1, {NUM_WAYS{1'b1}}} : {1'b0, ~b};
  endfunction

  always_comb begin
    for (int w = 0; w < NUM_WAYS; w++) begin
      bad[w] = defect_map[SEL_W'({WAY_W'(w), rows[w*IDX_W +: IDX_W]})];
    end
  end

  assign {slow, way_en} = resolve(bad);

endmodule

// File: rtl/xr_set_lookup.sv
module xr_set_lookup #(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 32768,
  parameter int BLOCK_BYTES = 64,
  parameter int NUM_WAYS    = 4,
  localparam int NUM_SETS   = CACHE_BYTES / (BLOCK_BYTES * NUM_WAYS),
  localparam int OFF_W      = $clog2(BLOCK_BYTES),
  localparam int IDX_W      = $clog2(NUM_SETS),
  localparam int WAY_W      = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int TAG_W      = ADDR_W - IDX_W - OFF_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic                         fill_valid,
  input  logic [ADDR_W-1:0]            fill_addr,
  input  logic [WAY_W-1:0]             fill_way,
  input  logic                         remap_we,
  input  logic [WAY_W-1:0]             remap_way,
  input  logic [IDX_W-1:0]             remap_code,
  input  logic [NUM_WAYS*NUM_SETS-1:0] defect_map,
  output logic                         rsp_valid,
  output logic                         rsp_hit,
  output logic [WAY_W-1:0]             rsp_way,
  output logic [NUM_WAYS-1:0]          rsp_way_en,
  output logic                         rsp_slow,
  output logic [2:0]                   rsp_lat
);

  import xr_lookup_pkg::*;

  function automatic logic [IDX_W-1:0] addr_idx(logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] addr_tag(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  // Lowest-numbered set bit of a match vector.
  function automatic logic [WAY_W-1:0] first_way(logic [NUM_WAYS-1:0] m);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (m[w]) r = WAY_W'(w);
    end
    return r;
  endfunction

  // Named internal events, observed by the bound checker.
  logic                      remap_accept;
  logic [NUM_WAYS*IDX_W-1:0] remap_codes;
  logic [NUM_WAYS-1:0]       way_en;
  logic                      set_slow;
  logic [NUM_WAYS-1:0]       match_vec;

  logic [IDX_W-1:0]          req_idx;
  logic [TAG_W-1:0]          req_tag;
  logic [NUM_WAYS*IDX_W-1:0] lk_rows;
  logic [IDX_W-1:0]          fl_row;
  logic [NUM_WAYS-1:0]       rd_valid;
  logic [NUM_WAYS*TAG_W-1:0] rd_tags;
  logic                      unused_offsets;

  assign unused_offsets = ^{req_addr[OFF_W-1:0], fill_addr[OFF_W-1:0]};

  assign req_idx      = addr_idx(req_addr);
  assign req_tag      = addr_tag(req_addr);
  assign remap_accept = remap_we && !req_valid && !fill_valid;

  xr_remap_bank #(
    .NUM_WAYS (NUM_WAYS),
    .IDX_W    (IDX_W),
    .WAY_W    (WAY_W)
  ) remap_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (remap_accept),
    .wr_way  (remap_way),
    .wr_code (remap_code),
    .lk_idx  (req_idx),
    .fl_idx  (addr_idx(fill_addr)),
    .fl_way  (fill_way),
    .lk_rows (lk_rows),
    .fl_row  (fl_row),
    .codes   (remap_codes)
  );

  xr_tag_bank #(
    .NUM_WAYS (NUM_WAYS),
    .NUM_SETS (NUM_SETS),
    .IDX_W    (IDX_W),
    .WAY_W    (WAY_W),
    .TAG_W    (TAG_W)
  ) tags_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (remap_accept),
    .wr_en    (fill_valid),
    .wr_way   (fill_way),
    .wr_row   (fl_row),
    .wr_tag   (addr_tag(fill_addr)),
    .rd_rows  (lk_rows),
    .rd_valid (rd_valid),
    .rd_tags  (rd_tags)
  );

  xr_turnoff #(
    .NUM_WAYS (NUM_WAYS),
    .NUM_SETS (NUM_SETS),
    .IDX_W    (IDX_W),
    .WAY_W    (WAY_W)
  ) turnoff_i (
    .defect_map (defect_map),
    .rows       (lk_rows),
    .way_en     (way_en),
    .slow       (set_slow)
  );

  always_comb begin
    for (int w = 0; w < NUM_WAYS; w++) begin
      match_vec[w] = way_en[w] && rd_valid[w] && (rd_tags[w*TAG_W +: TAG_W] == req_tag);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_way    <= '0;
      rsp_way_en <= '0;
      rsp_slow   <= 1'b0;
      rsp_lat    <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit    <= |match_vec;
        rsp_way    <= first_way(match_vec);
        rsp_way_en <= way_en;
        rsp_slow   <= set_slow;
        rsp_lat    <= lat_cycles(set_slow ? LAT_SLOW : LAT_FAST);
      end
    end
  end

endmodule

// File: rtl/xr_set_lookup_chk.sv
module xr_set_lookup_chk #(
  parameter int NUM_WAYS = 4,
  parameter int WAY_W    = 2,
  parameter int CODES_W  = 28
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                fill_valid,
  input logic                remap_we,
  input logic                remap_accept,
  input logic [CODES_W-1:0]  remap_codes,
  input logic                rsp_valid,
  input logic                rsp_hit,
  input logic [WAY_W-1:0]    rsp_way,
  input logic [NUM_WAYS-1:0] rsp_way_en,
  input logic                rsp_slow,
  input logic [2:0]          rsp_lat
);

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R9
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rsp_valid); // R9
  AST_ONE_WAY_LIVE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> (rsp_way_en != '0)); // R5
  AST_SLOW_KEEPS_ALL: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_slow) |-> (&rsp_way_en)); // R5
  AST_FAST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_slow) |-> (rsp_lat == 3'd2)); // R4
  AST_SLOW_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_slow) |-> (rsp_lat == 3'd4)); // R5
  AST_HIT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_hit) |-> rsp_way_en[rsp_way]); // R7
  AST_MISS_WAY_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_hit) |-> (rsp_way == '0)); // R8
  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n) (remap_we && (req_valid || fill_valid)) |=> $stable(remap_codes)); // R11
  AST_CLEAR_MISSES: assert property (@(posedge clk) disable iff (!rst_n) (remap_accept ##1 req_valid) |=> !rsp_hit); // R11

endmodule

bind xr_set_lookup xr_set_lookup_chk #(
  .NUM_WAYS (NUM_WAYS),
  .WAY_W    (WAY_W),
  .CODES_W  (NUM_WAYS*IDX_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .fill_valid   (fill_valid),
  .remap_we     (remap_we),
  .remap_accept (remap_accept),
  .remap_codes  (remap_codes),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .rsp_way      (rsp_way),
  .rsp_way_en   (rsp_way_en),
  .rsp_slow     (rsp_slow),
  .rsp_lat      (rsp_lat)
);

// File: tb/xr_set_lookup_tb_top.sv
`timescale 1ns/1ps
module xr_set_lookup_tb_top;

  localparam int SETS = 128;
  localparam int WAYS = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [31:0]  req_addr = '0;
  logic         fill_valid = 1'b0;
  logic [31:0]  fill_addr = '0;
  logic [1:0]   fill_way = '0;
  logic         remap_we = 1'b0;
  logic [1:0]   remap_way = '0;
  logic [6:0]   remap_code = '0;
  logic [511:0] defect_map = '0;
  logic         rsp_valid, rsp_hit, rsp_slow;
  logic [1:0]   rsp_way;
  logic [3:0]   rsp_way_en;
  logic [2:0]   rsp_lat;

  always #2 clk = ~clk;

  xr_set_lookup dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_way(fill_way),
    .remap_we(remap_we), .remap_way(remap_way), .remap_code(remap_code),
    .defect_map(defect_map), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_way(rsp_way), .rsp_way_en(rsp_way_en), .rsp_slow(rsp_slow), .rsp_lat(rsp_lat)
  );

  typedef struct {
    bit       hit;
    int       way;
    bit [3:0] en;
    bit       slow;
    int       lat;
    string    lbl;
  } exp_t;

  exp_t      expq[$];
  int        n_chk = 0;
  int        n_bad = 0;
  bit        done = 0;
  bit [6:0]  m_code [WAYS];
  bit        m_vld  [WAYS][SETS];
  bit [18:0] m_tag  [WAYS][SETS];

  task automatic check(input bit ok, input string lbl, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s actual=%0d expected=%0d", lbl, what, act, exp);
    end
  endtask

  // Expected response from the requirements, using the state before the edge.
  function automatic exp_t predict(bit [18:0] t, bit [6:0] idx, string lbl);
    exp_t e;
    bit [3:0] bad;
    int row [WAYS];
    for (int w = 0; w < WAYS; w++) begin
      row[w] = int'(idx ^ m_code[w]);
      bad[w] = defect_map[w*SETS + row[w]];
    end
    e.slow = (bad == 4'hF);                 // R5
    e.en   = e.slow ? 4'hF : ~bad;          // R3 R4
    e.lat  = e.slow ? 4 : 2;
    e.hit  = 0;
    e.way  = 0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (e.en[w] && m_vld[w][row[w]] && m_tag[w][row[w]] == t) begin
        e.hit = 1;
        e.way = w;
      end
    end
    e.lbl = lbl;
    return e;
  endfunction

  // One cycle of stimulus, driven from a falling edge.
  task automatic step(input bit rq, input bit [18:0] rt, input bit [6:0] ri, input bit [5:0] ro,
                      input bit fl, input bit [1:0] fw, input bit [18:0] ft, input bit [6:0] fi,
                      input bit rm, input bit [1:0] rw, input bit [6:0] rc, input string lbl);
    req_valid  = rq;  req_addr  = {rt, ri, ro};
    fill_valid = fl;  fill_way  = fw;  fill_addr = {ft, fi, 6'h00};
    remap_we   = rm;  remap_way = rw;  remap_code = rc;
    if (rq) expq.push_back(predict(rt, ri, lbl));
    if (fl) begin
      m_vld[fw][fi ^ m_code[fw]] = 1;
      m_tag[fw][fi ^ m_code[fw]] = ft;
    end
    if (rm && !rq && !fl) begin               // R11
      m_code[rw] = rc;
      for (int w = 0; w < WAYS; w++)
        for (int s = 0; s < SETS; s++) m_vld[w][s] = 0;
    end
    @(negedge clk);
    req_valid = 0; fill_valid = 0; remap_we = 0;
  endtask

  task automatic lookup(input bit [18:0] t, input bit [6:0] i, input string lbl);
    step(1, t, i, 6'h00, 0, 0, 0, 0, 0, 0, 0, lbl);
  endtask

  task automatic fill(input bit [1:0] w, input bit [18:0] t, input bit [6:0] i);
    step(0, 0, 0, 0, 1, w, t, i, 0, 0, 0, "");
  endtask

  task automatic remap(input bit [1:0] w, input bit [6:0] c);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, w, c, "");
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Scoreboard monitor: one response per request, one cycle later.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rsp_valid) begin
        if (expq.size() == 0) begin
          check(0, "R9", "unexpected rsp_valid", 1, 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(rsp_hit == e.hit, e.lbl, "hit", int'(rsp_hit), int'(e.hit));
          check(int'(rsp_way) == e.way, e.lbl, "way", int'(rsp_way), e.way);
          check(rsp_way_en == e.en, e.lbl, "way_en", int'(rsp_way_en), int'(e.en));
          check(rsp_slow == e.slow, e.lbl, "slow", int'(rsp_slow), int'(e.slow));
          check(int'(rsp_lat) == e.lat, e.lbl, "latency", int'(rsp_lat), e.lat);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < WAYS; w++) begin
      m_code[w] = 0;
      for (int s = 0; s < SETS; s++) begin
        m_vld[w][s] = 0;
        m_tag[w][s] = 0;
      end
    end
    repeat (3) @(negedge clk);
    check(rsp_valid == 0, "R12", "rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    check(rsp_valid == 0, "R12", "rsp_valid after reset", int'(rsp_valid), 0);
    lookup(19'h00100, 7'd5, "R12");            // nothing valid yet

    // Clean set: hit with all ways on, short latency
    fill(2'd0, 19'h00100, 7'd5);
    lookup(19'h00100, 7'd5, "R3");

    // Fill and lookup of the same set in one cycle
    step(1, 19'h00200, 7'd9, 6'h00, 1, 2'd1, 19'h00200, 7'd9, 0, 0, 0, "R10");
    lookup(19'h00200, 7'd9, "R10");

    // Taken code write clears every line
    remap(2'd2, 7'h10);
    lookup(19'h00100, 7'd5, "R11");

    // Way 2 now keeps logical set 3 in physical row 19
    fill(2'd2, 19'h00300, 7'd3);
    lookup(19'h00300, 7'd3, "R2");
    defect_map[2*SETS + 19] = 1'b1;
    lookup(19'h00300, 7'd3, "R7");             // mixed set, way 2 dark: miss
    lookup(19'h00300, 7'd3, "R4");
    defect_map[2*SETS + 19] = 1'b0;
    defect_map[2*SETS + 3]  = 1'b1;            // R6: row not read by way 2
    lookup(19'h00300, 7'd3, "R6");
    defect_map[0*SETS + 3]  = 1'b1;
    defect_map[1*SETS + 3]  = 1'b1;
    defect_map[3*SETS + 3]  = 1'b1;
    defect_map[2*SETS + 19] = 1'b1;
    lookup(19'h00300, 7'd3, "R5");             // all read blocks slow
    defect_map = '0;

    // Code write during a lookup is dropped
    step(1, 19'h00300, 7'd3, 6'h00, 0, 0, 0, 0, 1, 2'd2, 7'h00, "R11");
    lookup(19'h00300, 7'd3, "R11");
    // Code write during a fill is dropped
    step(0, 0, 0, 0, 1, 2'd1, 19'h00555, 7'd60, 1, 2'd2, 7'h00, "R11");
    lookup(19'h00300, 7'd3, "R11");

    // Priority among duplicate tags, then turnoff of the lower way
    fill(2'd0, 19'h00400, 7'd40);
    fill(2'd3, 19'h00400, 7'd40);
    lookup(19'h00400, 7'd40, "R8");
    defect_map[0*SETS + 40] = 1'b1;
    lookup(19'h00400, 7'd40, "R7");
    defect_map = '0;
    step(1, 19'h00400, 7'd40, 6'h3F, 0, 0, 0, 0, 0, 0, 0, "R1");
    lookup(19'h00401, 7'd40, "R8");

    // Mixed random traffic in a small corner of the cache
    for (int k = 0; k < 400; k++) begin
      int op;
      bit [1:0] w;
      bit [6:0] i;
      bit [18:0] t;
      op = int'($urandom_range(0, 9));
      w  = 2'($urandom_range(0, 3));
      i  = 7'($urandom_range(0, 7));
      t  = 19'($urandom_range(0, 3));
      case (op)
        0, 1: fill(w, t, i);
        2, 3, 4: lookup(t, i, "R8");
        5: step(1, t, i, 6'($urandom), 1, w, 19'($urandom_range(0, 3)), i, 0, 0, 0, "R10");
        6: defect_map[int'(w)*SETS + int'($urandom_range(0, 7))] ^= 1'b1;
        7: if ($urandom_range(0, 3) == 0) remap(w, 7'(1 << $urandom_range(0, 2)));
           else lookup(t, i, "R4");
        default: step(1, t, i, 6'h00, 0, 0, 0, 0, 1, w, 7'($urandom_range(0, 7)), "R11");
      endcase
    end

    idle(3);
    check(expq.size() == 0, "R9", "responses missing", expq.size(), 0);
    check(rsp_valid == 0, "R9", "rsp_valid while idle", int'(rsp_valid), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule